// File: doc/BRIEF.md
# Capture Sample Byte Read Sequencer

This block sits between a capture FIFO that delivers whole audio samples and an 8-bit host data port used for programmed I/O reads. It keeps one sample in a holding register and steps a byte pointer through that sample, one byte per host read. The pointer position is also driven out so that a status register can show which byte the host will get next.

When the last byte of a sample has been reached, the pointer stays there. Further host reads keep returning that byte. A new sample replaces the held one only when two things are both true: the host has read status, and the FIFO has a sample ready. A status read is remembered until the sample arrives. While the codec is initializing or powered down, the port returns a fixed pattern and host activity is ignored. The sample format is a static input.

Top module: `capture_byte_seq`

## Requirements
- R1: After synchronous active-low reset, `next_idx` is 0, `sample_valid` is 0, `fifo_pop` is 0 and `rd_data` is 0x00.
- R2: The `fmt` input sets the number of bytes per sample. Code 00 gives 1 byte (8-bit mono). Codes 01 and 10 give 2 bytes (8-bit stereo, 16-bit mono). Code 11 gives 4 bytes (16-bit stereo). Byte k of the sample is `fifo_data[8k+7:8k]`, which gives the order left-low, left-high, right-low, right-high.
- R3: While a sample is held, `rd_data` shows the byte selected by the pointer. A host read moves the pointer one place forward, so the next read returns the following byte.
- R4: `next_idx` always equals the index of the byte that the next host read returns.
- R5: Once the pointer is on the last byte, further host reads leave it there, and `rd_data` keeps returning the last byte.
- R6: While no sample is held, a non-empty FIFO is loaded at the next clock edge without any status read.
- R7: Once a sample is held, a new sample is loaded only when a status read is pending and the FIFO is not empty. `fifo_pop` is high in the cycle of the load, and the pointer returns to 0.
- R8: A status read that arrives while the FIFO is empty stays pending. The load then happens as soon as a sample arrives.
- R9: `fifo_pop` is never asserted while `fifo_empty` is high.
- R10: While `codec_idle` is high, `rd_data` is 0x80. Host reads and status reads are ignored and the FIFO is not popped. The pointer and the held sample are unchanged when `codec_idle` falls.
- R11: A host read in the same cycle as a load returns the old byte, and the pointer then starts at byte 0 of the new sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| codec_idle | input | 1 | Codec is initializing or powered down |
| fmt | input | 2 | Sample format code (static) |
| fifo_empty | input | 1 | The capture FIFO has no sample |
| fifo_data | input | 32 | Head sample of the FIFO |
| fifo_pop | output | 1 | Pop strobe; high in the load cycle |
| host_rd | input | 1 | Host read strobe for the data port |
| status_rd | input | 1 | Host read strobe for the status register |
| rd_data | output | 8 | Data port read value |
| next_idx | output | 2 | Index of the next byte to be read |
| sample_valid | output | 1 | A sample is held |

## Verification
A host read and a sample load can occur in the same cycle. In that cycle the read consumes a byte of the outgoing sample, and the load resets the pointer for the incoming one. The bench provokes this by raising the host read and status read strobes together while the FIFO holds a new word. It first checks that `rd_data` still shows byte 0 of the old sample before the edge. After the edge it checks that `next_idx` is 0 and that `rd_data` is byte 0 of the new word, not byte 1.

// File: rtl/capture_seq_pkg.sv
// Package: shared types and helpers for the capture byte sequencer.
// Assumes at most four bytes per sample and 8-bit host data.
package capture_seq_pkg;

    localparam int BYTE_W    = 8;
    localparam int MAX_BYTES = 4;

    typedef enum logic [1:0] {
        FMT_U8_MONO    = 2'b00,
        FMT_U8_STEREO  = 2'b01,
        FMT_S16_MONO   = 2'b10,
        FMT_S16_STEREO = 2'b11
    } cap_fmt_e;

    // Bytes carried by one sample of the given format.
    function automatic int byte_count(input cap_fmt_e f);
        case (f)
            FMT_U8_MONO:    return 1;
            FMT_U8_STEREO:  return 2;
            FMT_S16_MONO:   return 2;
            default:        return 4;
        endcase
    endfunction

endpackage

// File: rtl/cap_pending_flag.sv
// Sticky flag that remembers a status read until a sample load consumes it.
// Assumes that clear (load) takes priority over a set in the same cycle,
// because that load already honours the set.
module cap_pending_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);

    logic pend_q;

    // Set on a status read; clear when a load uses it.
    always_ff @(posedge clk) begin
        if (!rst_n)      pend_q <= 1'b0;
        else if (clr_i)  pend_q <= 1'b0;
        else if (set_i)  pend_q <= 1'b1;
    end

    assign pend_o = pend_q;

    // R8: a pending status read survives until a load consumes it
    assert_pending_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !clr_i) |=> pend_q);

    // R8: a set without a clear always leaves the flag raised
    assert_pending_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !clr_i) |=> pend_q);

endmodule

// File: rtl/cap_byte_ptr.sv
// Byte pointer within the held sample. It steps forward on an accepted read,
// stops at the last byte, and returns to zero when a sample is loaded.
// Assumes that last_i is static while a sample is held.
module cap_byte_ptr #(
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             adv_i,
    input  logic [IDX_W-1:0] last_i,
    output logic [IDX_W-1:0] ptr_o
);

    logic [IDX_W-1:0] ptr_q;
    logic             at_last;

    // Detect the final byte of the current sample.
    always_comb at_last = (ptr_q == last_i);

    // Load resets the pointer; an accepted read advances it unless it is at the end.
    always_ff @(posedge clk) begin
        if (!rst_n)                  ptr_q <= '0;
        else if (load_i)             ptr_q <= '0;
        else if (adv_i && !at_last)  ptr_q <= ptr_q + 1'b1;
    end

    assign ptr_o = ptr_q;

    // R2: the pointer never passes the last byte of the format
    assert_ptr_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= last_i);

    // R3: a read before the end moves the pointer one place forward
    assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !load_i && ptr_q != last_i) |=> ptr_q == $past(ptr_q) + 1'b1);

    // R5: a read at the end leaves the pointer where it is
    assert_ptr_hold_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !load_i && ptr_q == last_i) |=> $stable(ptr_q));

    // R7: a load restarts at byte zero
    assert_ptr_load_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> ptr_q == '0);

endmodule

// File: rtl/cap_hold_reg.sv
// Holding register for one captured sample, with a byte-lane selector.
// Assumes the word is LANES bytes wide and that lane 0 is the least significant byte.
module cap_hold_reg #(
    parameter int BYTE_W = 8,
    parameter int LANES  = 4,
    parameter int IDX_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_i,
    input  logic [LANES*BYTE_W-1:0] word_i,
    input  logic [IDX_W-1:0]        sel_i,
    output logic                    valid_o,
    output logic [BYTE_W-1:0]       byte_o
);

    logic [LANES*BYTE_W-1:0] word_q;
    logic                    valid_q;
    logic [BYTE_W-1:0]       lane [LANES];

    // Capture a whole sample on load and mark it held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q  <= '0;
            valid_q <= 1'b0;
        end else if (load_i) begin
            word_q  <= word_i;
            valid_q <= 1'b1;
        end
    end

    // Split the held word into byte lanes.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane[g] = word_q[g*BYTE_W +: BYTE_W];
    end

    // Pick the lane the pointer addresses.
    always_comb byte_o = lane[sel_i];

    assign valid_o = valid_q;

    // R7: the held sample changes only on a load
    assert_word_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(word_q));

    // R6: once a sample is held, the valid flag stays high
    assert_valid_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> valid_q);

endmodule

// File: rtl/capture_byte_seq.sv
// Top of the capture byte read sequencer. It decides when to pop the FIFO,
// gates host strobes while the codec is idle, and forms the port read value.
// Assumes fmt is static and that fifo_data is valid whenever fifo_empty is low.
module capture_byte_seq
    import capture_seq_pkg::*;
#(
    parameter int               BYTE_W    = capture_seq_pkg::BYTE_W,
    parameter int               MAX_BYTES = capture_seq_pkg::MAX_BYTES,
    parameter logic [BYTE_W-1:0] IDLE_PATTERN = 8'h80,
    localparam int              IDX_W     = $clog2(MAX_BYTES),
    localparam int              WORD_W    = MAX_BYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              codec_idle,
    input  logic [1:0]        fmt,
    input  logic              fifo_empty,
    input  logic [WORD_W-1:0] fifo_data,
    output logic              fifo_pop,
    input  logic              host_rd,
    input  logic              status_rd,
    output logic [BYTE_W-1:0] rd_data,
    output logic [IDX_W-1:0]  next_idx,
    output logic              sample_valid
);

    logic [IDX_W-1:0]  last_idx;
    logic              rd_ok;
    logic              st_ok;
    logic              pend_q;
    logic              load;
    logic              valid;
    logic [IDX_W-1:0]  ptr;
    logic [BYTE_W-1:0] sel_byte;

    // Last byte index for the selected format.
    always_comb last_idx = IDX_W'(byte_count(cap_fmt_e'(fmt)) - 1);

    // Host strobes count only while the codec is running.
    always_comb begin
        rd_ok = host_rd   && !codec_idle;
        st_ok = status_rd && !codec_idle;
    end

    // Load when data is ready and either no sample is held or a status read is pending.
    always_comb load = !codec_idle && !fifo_empty && (!valid || pend_q || st_ok);

    cap_pending_flag i_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (st_ok),
        .clr_i  (load),
        .pend_o (pend_q)
    );

    cap_byte_ptr #(.IDX_W(IDX_W)) i_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .adv_i  (rd_ok && valid),
        .last_i (last_idx),
        .ptr_o  (ptr)
    );

    cap_hold_reg #(.BYTE_W(BYTE_W), .LANES(MAX_BYTES), .IDX_W(IDX_W)) i_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .word_i  (fifo_data),
        .sel_i   (ptr),
        .valid_o (valid),
        .byte_o  (sel_byte)
    );

    // Drive the port: a fixed pattern while idle, otherwise the addressed byte.
    always_comb begin
        rd_data      = codec_idle ? IDLE_PATTERN : sel_byte;
        fifo_pop     = load;
        next_idx     = ptr;
        sample_valid = valid;
    end

    // R9: never pop an empty FIFO
    assert_no_pop_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> !fifo_empty);

    // R10: no pop while the codec is idle
    assert_idle_no_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        codec_idle |-> !fifo_pop);

    // R10: the pointer does not move while the codec is idle
    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        codec_idle |=> $stable(next_idx));

    // R7: with a sample held and no status read at all, no pop happens
    assert_need_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && !pend_q && !status_rd) |-> !fifo_pop);

endmodule

// File: tb/test_capture_byte_seq.sv
`timescale 1ns/100ps
module test_capture_byte_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        codec_idle = 1'b0;
    logic [1:0]  fmt = 2'b00;
    logic        fifo_empty;
    logic [31:0] fifo_data;
    logic        fifo_pop;
    logic        host_rd = 1'b0;
    logic        status_rd = 1'b0;
    logic [7:0]  rd_data;
    logic [1:0]  next_idx;
    logic        sample_valid;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // FIFO model
    logic [31:0] q [0:15];
    int wr_i = 0;
    int rd_i = 0;
    bit pop_empty_seen = 1'b0;

    assign fifo_empty = (wr_i == rd_i);
    assign fifo_data  = q[rd_i % 16];

    always #2.5 clk = ~clk;

    capture_byte_seq i_capture_byte_seq (
        .clk(clk), .rst_n(rst_n), .codec_idle(codec_idle), .fmt(fmt),
        .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_pop(fifo_pop),
        .host_rd(host_rd), .status_rd(status_rd), .rd_data(rd_data),
        .next_idx(next_idx), .sample_valid(sample_valid)
    );

    always @(posedge clk) begin
        if (rst_n && fifo_pop) begin
            if (wr_i == rd_i) pop_empty_seen = 1'b1;
            rd_i <= rd_i + 1;
        end
    end

    function automatic int nbytes(input int f);
        return (f == 0) ? 1 : (f == 3) ? 4 : 2;
    endfunction

    function automatic logic [7:0] bsel(input logic [31:0] w, input int k);
        return w[8*k +: 8];
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [31:0] w);
        q[wr_i % 16] = w;
        wr_i++;
    endtask

    task automatic hread();
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic sread();
        status_rd = 1'b1;
        @(negedge clk);
        status_rd = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] cur;
        logic [31:0] nw;
        int pops;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(next_idx == 2'd0, "R1 next_idx", next_idx, 0);
        chk(sample_valid == 1'b0, "R1 sample_valid", sample_valid, 0);
        chk(fifo_pop == 1'b0, "R1 fifo_pop", fifo_pop, 0);
        chk(rd_data == 8'h00, "R1 rd_data", rd_data, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sample_valid == 1'b0, "R1 idle after reset", sample_valid, 0);

        // R6: first sample loads without status read
        cur = 32'hA1B2C3D4;
        push(cur);
        @(negedge clk);
        chk(sample_valid == 1'b1, "R6 first load", sample_valid, 1);
        chk(rd_i == 1, "R6 pop count", rd_i, 1);

        for (int f = 0; f < 4; f++) begin
            int nb;
            fmt = f[1:0];
            nb = nbytes(f);
            for (int k = 0; k < nb; k++) begin
                chk(next_idx == k[1:0], "R4 next_idx", next_idx, k);
                chk(rd_data == bsel(cur, k), "R2 R3 byte order", rd_data, bsel(cur, k));
                hread();
            end
            for (int e = 0; e < 3; e++) begin
                chk(next_idx == 2'(nb - 1), "R5 hold index", next_idx, nb - 1);
                chk(rd_data == bsel(cur, nb - 1), "R5 hold byte", rd_data, bsel(cur, nb - 1));
                hread();
            end
            nw = 32'h10203040 + 32'h01010101 * (f + 1) * 7;
            pops = rd_i;
            push(nw);
            repeat (2) @(negedge clk);
            chk(rd_i == pops, "R7 no load without status", rd_i, pops);
            chk(rd_data == bsel(cur, nb - 1), "R7 old sample kept", rd_data, bsel(cur, nb - 1));
            sread();
            chk(rd_i == pops + 1, "R7 pop on load", rd_i, pops + 1);
            chk(next_idx == 2'd0, "R7 pointer zero", next_idx, 0);
            chk(rd_data == bsel(nw, 0), "R7 new byte0", rd_data, bsel(nw, 0));
            cur = nw;
        end

        // R8 and R9: status read while the FIFO is empty
        hread();
        pops = rd_i;
        sread();
        repeat (3) @(negedge clk);
        chk(rd_i == pops, "R9 no pop while empty", rd_i, pops);
        chk(next_idx == 2'd1, "R8 waiting", next_idx, 1);
        nw = 32'hDEADBEEF;
        push(nw);
        @(negedge clk);
        chk(rd_i == pops + 1, "R8 sticky load", rd_i, pops + 1);
        chk(next_idx == 2'd0, "R8 pointer zero", next_idx, 0);
        chk(rd_data == bsel(nw, 0), "R8 new byte0", rd_data, bsel(nw, 0));
        cur = nw;

        // R10: idle codec
        hread();
        codec_idle = 1'b1;
        @(negedge clk);
        chk(rd_data == 8'h80, "R10 idle pattern", rd_data, 8'h80);
        pops = rd_i;
        hread();
        hread();
        sread();
        push(32'h55667788);
        repeat (3) @(negedge clk);
        chk(rd_data == 8'h80, "R10 idle pattern held", rd_data, 8'h80);
        chk(rd_i == pops, "R10 no pop while idle", rd_i, pops);
        codec_idle = 1'b0;
        @(negedge clk);
        chk(next_idx == 2'd1, "R10 pointer unchanged", next_idx, 1);
        chk(rd_data == bsel(cur, 1), "R10 byte unchanged", rd_data, bsel(cur, 1));
        chk(rd_i == pops, "R10 status ignored", rd_i, pops);
        sread();
        cur = 32'h55667788;
        chk(rd_data == bsel(cur, 0), "R7 load after idle", rd_data, bsel(cur, 0));

        // R11: host read coinciding with a load
        nw = 32'h0F1E2D3C;
        push(nw);
        host_rd = 1'b1;
        status_rd = 1'b1;
        #1;
        chk(rd_data == bsel(cur, 0), "R11 old byte returned", rd_data, bsel(cur, 0));
        @(negedge clk);
        host_rd = 1'b0;
        status_rd = 1'b0;
        chk(next_idx == 2'd0, "R11 pointer zero", next_idx, 0);
        chk(rd_data == bsel(nw, 0), "R11 new byte0", rd_data, bsel(nw, 0));

        chk(!pop_empty_seen, "R9 pop on empty", pop_empty_seen, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule